// File: doc/BRIEF.md
# I/O Access Trap Capture Unit

This unit watches accesses to a small disk-controller I/O window while that window is in its normal, non-configuration mode. When trapping is switched on, every read or write on the window is turned into a one-cycle system-management interrupt request. The unit also stores a short record of the access so that handler code can replay it in software. The record holds two address bits, a code for the byte lanes used, and, for byte writes only, the written data. Reads on the window always return all ones at the access width. The unit does not supply any real drive data.

A second, independent job runs alongside the trap. Every 16-bit read of window offset 1 steps a small unlock counter, whether or not trapping is on. When the counter wraps back to zero, the unit raises a one-cycle unlock request. The surrounding logic uses that request to enter configuration mode.

Trap sequencing is a two-state machine. `ST_IDLE` is the resting state. Any access made with trapping enabled takes the transition *trap-hit* into `ST_TRAP`, in which the interrupt output is high. `ST_TRAP` leaves through *trap-hit* again, staying in `ST_TRAP` for a back-to-back access, or through *no-hit*, which returns to `ST_IDLE`. The capture record is loaded on the same edge that enters `ST_TRAP`.

Top module: `iotrap_capture`

## Requirements
- R1: With `trap_en` low, an access raises no interrupt, and `cap_reg` and `data_latch` keep their previous values.
- R2: An access made with `trap_en` high (`io_rd` or `io_wr` high) drives `smi_pulse` high for exactly the next cycle, then low unless another trapped access follows.
- R3: After a trapped access, `cap_reg[5]` equals address bit 9 and `cap_reg[4]` equals address bit 2. Bits 7:6 and 3:2 are zero.
- R4: For a trapped byte access (`io_size` = 00), `cap_reg[1:0]` equals address bits 1:0.
- R5: For a trapped 16-bit access (`io_size` = 01), `cap_reg[1]` equals address bit 1 and `cap_reg[0]` is 1.
- R6: For a trapped 32-bit access (`io_size` = 10 or 11), `cap_reg[1:0]` is 11.
- R7: A trapped byte write loads `io_wdata[7:0]` into `data_latch`.
- R8: Any other trapped access (a read of any width, or a 16-bit or 32-bit write) clears `data_latch` to zero.
- R9: While `io_rd` is high, `rd_data` is 0x000000FF for a byte read, 0x0000FFFF for a 16-bit read and 0xFFFFFFFF for a 32-bit read. It is zero when no read is made. This holds whatever the value of `trap_en`.
- R10: The unlock counter counts every 16-bit read whose address bits 2:0 are 001, regardless of `trap_en`. Every second such read drives `unlock_req` high for exactly the next cycle.
- R11: After reset, `smi_pulse`, `unlock_req`, `cap_reg` and `data_latch` are all zero, and the unlock count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W (10) | Access address |
| io_size | input | 2 | Access width: 00 byte, 01 16-bit, 10 or 11 32-bit |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | DATA_W (32) | Write data |
| trap_en | input | 1 | Trapping enable |
| rd_data | output | DATA_W (32) | Read data, all ones at the access width |
| smi_pulse | output | 1 | One-cycle interrupt request per trapped access |
| cap_reg | output | 8 | Capture record of the last trapped access |
| data_latch | output | 8 | Byte-write data of the last trapped access, or zero |
| unlock_req | output | 1 | One-cycle pulse on every second 16-bit read of offset 1 |

## Verification
The hardest case to reach is the unlock counter. Its phase cannot be seen at the ports, and any 16-bit read of offset 1 moves it, including reads issued by other scenarios and reads made with trapping off. The bench therefore keeps its own copy of the counter phase and updates it on every qualifying read in every task. It checks `unlock_req` after each access, so the pulse must appear on the second read of a pair even when the pair is split across scenarios and trap settings. The hold requirement is checked by trapping an access first, then running disabled accesses and confirming that the earlier record survives.

// File: rtl/iotrap_pkg.sv
package iotrap_pkg;

    // Access width code on io_size
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORDX = 2'b11
    } acc_size_e;

    // Trap sequencing states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } trap_state_e;

    // Layout of the capture record
    typedef struct packed {
        logic [1:0] zero_hi;
        logic       a_hi;
        logic       a_mid;
        logic [1:0] zero_lo;
        logic [1:0] lanes;
    } cap_rec_t;

endpackage

// File: rtl/iotrap_encoder.sv
module iotrap_encoder
    import iotrap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              a_hi,
    input  logic              a_mid,
    input  logic [1:0]        a_low,
    input  logic [1:0]        size,
    output logic [7:0]        cap_byte,
    output logic [DATA_W-1:0] rd_mask
);
    localparam int BYTE_BITS = 8;
    localparam int HALF_BITS = 16;

    cap_rec_t  rec;
    acc_size_e sz;
    int        width_bits;

    assign sz = acc_size_e'(size);

    always_comb begin
        rec         = '0;
        rec.a_hi    = a_hi;
        rec.a_mid   = a_mid;
        width_bits  = DATA_W;
        unique case (sz)
            SZ_BYTE: begin
                rec.lanes  = a_low;
                width_bits = BYTE_BITS;
            end
            SZ_HALF: begin
                rec.lanes  = {a_low[1], 1'b1};
                width_bits = HALF_BITS;
            end
            SZ_WORD, SZ_WORDX: begin
                rec.lanes  = 2'b11;
                width_bits = DATA_W;
            end
        endcase
    end

    assign cap_byte = rec;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign rd_mask[i] = (i < width_bits);
    end

endmodule

// File: rtl/iotrap_unlock.sv
module iotrap_unlock
    import iotrap_pkg::*;
#(
    parameter int       TRY_W      = 1,
    parameter bit [2:0] UNLOCK_OFS = 3'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic [1:0] size,
    input  logic [2:0] ofs,
    output logic       unlock_req
);
    logic [TRY_W-1:0] tries;
    logic             qualify;
    logic [TRY_W-1:0] tries_nxt;

    assign qualify   = rd && (acc_size_e'(size) == SZ_HALF) && (ofs == UNLOCK_OFS);
    assign tries_nxt = tries + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries      <= '0;
            unlock_req <= 1'b0;
        end else begin
            unlock_req <= 1'b0;
            if (qualify) begin
                tries      <= tries_nxt;
                unlock_req <= (tries_nxt == '0);
            end
        end
    end

endmodule

// File: rtl/iotrap_fsm.sv
module iotrap_fsm
    import iotrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic smi
);
    trap_state_e state, state_nxt;

    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE: state_nxt = hit ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_nxt = hit ? ST_TRAP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb smi = (state == ST_TRAP);

endmodule

// File: rtl/iotrap_capture.sv
module iotrap_capture
    import iotrap_pkg::*;
#(
    parameter int       ADDR_W     = 10,
    parameter int       DATA_W     = 32,
    parameter int       TRY_W      = 1,
    parameter bit [2:0] UNLOCK_OFS = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              trap_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              smi_pulse,
    output logic [7:0]        cap_reg,
    output logic [7:0]        data_latch,
    output logic              unlock_req
);
    localparam int HI_BIT  = 9;
    localparam int MID_BIT = 2;

    logic              hit;
    logic              byte_wr;
    logic [7:0]        cap_byte;
    logic [DATA_W-1:0] rd_mask;
    logic              addr_unused;
    logic              wdata_unused;

    assign addr_unused  = ^io_addr;
    assign wdata_unused = ^io_wdata[DATA_W-1:8];

    assign hit     = trap_en && (io_rd || io_wr);
    assign byte_wr = io_wr && (acc_size_e'(io_size) == SZ_BYTE);

    iotrap_encoder #(.DATA_W(DATA_W)) u_enc (
        .a_hi     (io_addr[HI_BIT]),
        .a_mid    (io_addr[MID_BIT]),
        .a_low    (io_addr[1:0]),
        .size     (io_size),
        .cap_byte (cap_byte),
        .rd_mask  (rd_mask)
    );

    iotrap_unlock #(.TRY_W(TRY_W), .UNLOCK_OFS(UNLOCK_OFS)) u_unl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (io_rd),
        .size       (io_size),
        .ofs        (io_addr[2:0]),
        .unlock_req (unlock_req)
    );

    iotrap_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .smi   (smi_pulse)
    );

    assign rd_data = io_rd ? rd_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_reg    <= '0;
            data_latch <= '0;
        end else if (hit) begin
            cap_reg    <= cap_byte;
            data_latch <= byte_wr ? io_wdata[7:0] : 8'h00;
        end
    end

endmodule

// File: rtl/iotrap_capture_chk.sv
module iotrap_capture_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        io_size,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        wbyte,
    input logic              trap_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              smi_pulse,
    input logic [7:0]        cap_reg,
    input logic [7:0]        data_latch
);
    logic trapped;
    assign trapped = trap_en && (io_rd || io_wr);

    // R1
    smi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(trapped));

    // R1
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trapped |=> ($stable(cap_reg) && $stable(data_latch)));

    // R2
    smi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trapped |=> smi_pulse);

    // R3
    cap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_reg[7:6] == 2'b00) && (cap_reg[3:2] == 2'b00));

    // R6
    word_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trapped && io_size[1]) |=> (cap_reg[1:0] == 2'b11));

    // R7
    byte_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en && io_wr && (io_size == 2'b00)) |=> (data_latch == $past(wbyte)));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en && io_rd && !io_wr) |=> (data_latch == 8'h00));

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (rd_data == '0));

endmodule

bind iotrap_capture iotrap_capture_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_size    (io_size),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .wbyte      (io_wdata[7:0]),
    .trap_en    (trap_en),
    .rd_data    (rd_data),
    .smi_pulse  (smi_pulse),
    .cap_reg    (cap_reg),
    .data_latch (data_latch)
);

// File: tb/iotrap_capture_test.sv
module iotrap_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic        trap_en = 1'b0;
    logic [31:0] rd_data;
    logic        smi_pulse;
    logic [7:0]  cap_reg;
    logic [7:0]  data_latch;
    logic        unlock_req;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_cap = '0;
    logic [7:0] m_lat = '0;
    logic       m_par = 1'b0;

    always #4 clk = ~clk;

    iotrap_capture uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .trap_en(trap_en),
        .rd_data(rd_data), .smi_pulse(smi_pulse), .cap_reg(cap_reg),
        .data_latch(data_latch), .unlock_req(unlock_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] width_ones(input logic [1:0] sz);
        if (sz == 2'b00) return 32'h0000_00FF;
        if (sz == 2'b01) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    // One access; checks read data, then all registered results one cycle later
    task automatic do_access(input logic [9:0] a, input logic [1:0] sz, input logic rd,
                             input logic wr, input logic [31:0] d, input logic en,
                             input string tag);
        logic hit;
        logic exp_unl;
        logic [1:0] lanes;
        @(negedge clk);
        io_addr = a; io_size = sz; io_rd = rd; io_wr = wr; io_wdata = d; trap_en = en;
        #1;
        chk("R9 rd_data", rd_data, rd ? width_ones(sz) : 32'h0);
        hit = en && (rd || wr);
        if (hit) begin
            if (sz == 2'b00)      lanes = a[1:0];
            else if (sz == 2'b01) lanes = {a[1], 1'b1};
            else                  lanes = 2'b11;
            m_cap = {2'b00, a[9], a[2], 2'b00, lanes};
            m_lat = (wr && sz == 2'b00) ? d[7:0] : 8'h00;
        end
        exp_unl = 1'b0;
        if (rd && sz == 2'b01 && a[2:0] == 3'd1) begin
            m_par   = ~m_par;
            exp_unl = (m_par == 1'b0);
        end
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        chk(hit ? "R2 smi high" : "R1 smi low", {31'b0, smi_pulse}, {31'b0, hit});
        chk({tag, " cap_reg"}, {24'b0, cap_reg}, {24'b0, m_cap});
        chk({tag, " data_latch"}, {24'b0, data_latch}, {24'b0, m_lat});
        chk("R10 unlock_req", {31'b0, unlock_req}, {31'b0, exp_unl});
        @(negedge clk);
        chk("R2 smi one cycle", {31'b0, smi_pulse}, 32'h0);
        chk("R10 unlock one cycle", {31'b0, unlock_req}, 32'h0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 smi", {31'b0, smi_pulse}, 32'h0);
        chk("R11 unlock", {31'b0, unlock_req}, 32'h0);
        chk("R11 cap", {24'b0, cap_reg}, 32'h0);
        chk("R11 latch", {24'b0, data_latch}, 32'h0);
    endtask

    task automatic t_byte_write();
        do_access(10'h205, 2'b00, 1'b0, 1'b1, 32'h1234_56A5, 1'b1, "R3 R4 R7");
        do_access(10'h002, 2'b00, 1'b0, 1'b1, 32'h0000_003C, 1'b1, "R4 R7");
    endtask

    task automatic t_disabled();
        do_access(10'h3FF, 2'b00, 1'b0, 1'b1, 32'h0000_0099, 1'b0, "R1 hold");
        do_access(10'h204, 2'b10, 1'b1, 1'b0, 32'h0, 1'b0, "R1 hold");
    endtask

    task automatic t_reads();
        do_access(10'h003, 2'b00, 1'b1, 1'b0, 32'h0, 1'b1, "R4 R8");
        do_access(10'h006, 2'b01, 1'b1, 1'b0, 32'h0, 1'b1, "R3 R5 R8");
        do_access(10'h204, 2'b10, 1'b1, 1'b0, 32'h0, 1'b1, "R3 R6 R8");
    endtask

    task automatic t_wide_writes();
        do_access(10'h001, 2'b00, 1'b0, 1'b1, 32'h0000_0077, 1'b1, "R7");
        do_access(10'h200, 2'b01, 1'b0, 1'b1, 32'h0000_BEEF, 1'b1, "R5 R8");
        do_access(10'h001, 2'b00, 1'b0, 1'b1, 32'h0000_0066, 1'b1, "R7");
        do_access(10'h204, 2'b11, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b1, "R6 R8");
    endtask

    task automatic t_unlock();
        do_access(10'h1F1, 2'b01, 1'b1, 1'b0, 32'h0, 1'b0, "R10 off");
        do_access(10'h1F1, 2'b01, 1'b1, 1'b0, 32'h0, 1'b0, "R10 off");
        do_access(10'h1F1, 2'b00, 1'b1, 1'b0, 32'h0, 1'b0, "R10 byte");
        do_access(10'h1F1, 2'b01, 1'b1, 1'b0, 32'h0, 1'b1, "R10 on");
        do_access(10'h1F3, 2'b01, 1'b1, 1'b0, 32'h0, 1'b1, "R10 ofs");
        do_access(10'h3F1, 2'b01, 1'b1, 1'b0, 32'h0, 1'b1, "R10 on");
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_byte_write();
        t_disabled();
        t_reads();
        t_wide_writes();
        t_unlock();
        t_disabled();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule